// File: doc/BRIEF.md
# Filtered Performance Event Counter

This block is a single hardware performance counter with a programmable filter in front of it. Every cycle it sees a set of raw event sources and the current privilege level. Each source is either a small per-cycle count or a per-unit bitmask, with one bit per execution unit. A configuration register picks one source. The filter then optionally restricts a bitmask source to a chosen subset of units, gates by privilege level, and compares the result against a threshold with an optional inversion. It can also reduce the filtered condition to its rising edges. The resulting per-cycle increment is added into a 64-bit count.

Software can overwrite the count at any time. When an increment carries the count from below 2^63 to 2^63 or above, an overflow is signalled. The block then latches an interrupt request if that is enabled, and toggles an external pin if that is enabled. Because overflow is taken at the top bit rather than at the 64-bit wrap, the full count stays readable as one unsigned value. Routing of the request and generation of the events are left to the surrounding logic.

Top module: `pfc_counter`

## Requirements
- R1: After reset the count is 0, the interrupt request and pin are low, and the configuration is all zero, so no privilege level is enabled and the count does not move.
- R2: The privilege code is 0 for user, 1 for supervisor and 2 for hypervisor. Mode-mask bit 0 enables user, bit 1 supervisor and bit 2 hypervisor. Code 3 never counts, and a level whose bit is clear adds nothing.
- R3: A configuration write takes effect on the following cycle. With a zero threshold and a count-type source, the count rises by the selected source's value at the clock edge that ends the cycle it is presented. Source k occupies event-vector bits [8k+7:8k].
- R4: Sources 1 and 3 are bitmasks: their quantity is the number of bits set in (source AND unit mask). Sources 0 and 2 are counts, for which the unit mask has no effect.
- R5: With a nonzero threshold, the count rises by exactly 1 when the quantity is greater than or equal to the threshold, and otherwise stays the same.
- R6: With a nonzero threshold and the invert bit set, the count rises by 1 only when the quantity is below the threshold. With a zero threshold, the invert bit has no effect.
- R7: The condition is "level enabled and (threshold zero ? quantity nonzero : comparison true)". With the edge bit set, the count rises by 1 only in a cycle where the condition holds and did not hold in the previous cycle.
- R8: A count write loads the written value and discards any increment of the same cycle. It also clears the edge history, so a true condition in the next cycle counts as a rising edge.
- R9: Overflow occurs only when an increment changes bit 63 from 0 to 1. A wrap from all ones to zero is not an overflow, and neither is a software write.
- R10: With interrupt-enable set, an overflow raises the interrupt request at the same edge that updates the count. The request then stays high until the next count write. With the bit clear, no request is raised.
- R11: With pin-control set, the pin inverts at each overflow. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_mode | input | 2 | Current privilege level code |
| evt_in | input | NUM_EVENTS*EVW | Raw event sources, one EVW-bit field each |
| cfg_we | input | 1 | Load the configuration fields below |
| cfg_sel | input | SELW | Source index |
| cfg_umask | input | EVW | Unit mask for bitmask sources |
| cfg_modes | input | 3 | Privilege-level enable mask |
| cfg_thresh | input | EVW | Threshold; zero means add the raw quantity |
| cfg_inv | input | 1 | Invert threshold comparison |
| cfg_edge | input | 1 | Count rising edges of the condition only |
| cfg_inten | input | 1 | Allow overflow to raise the interrupt request |
| cfg_pinctl | input | 1 | Allow overflow to toggle the pin |
| cnt_we | input | 1 | Software write of the count |
| cnt_wdata | input | CW | Value written to the count |
| count | output | CW | Current count |
| irq | output | 1 | Sticky overflow interrupt request |
| pin_out | output | 1 | Overflow toggle pin |

## Verification
A wrong quantity, threshold or privilege decision appears on `count` at the very next edge as a wrong step size. A stale or uncleared edge history shows up as a missing or extra unit of count. It appears on the first cycle after a count write, or on the first cycle of a burst. An overflow detector keyed to the wrong bit, or one that also fires on writes or wraps, shows on `irq` and `pin_out` in the same cycle the count crosses. The reference model therefore compares all three outputs on every clock, and the directed cases force each crossing explicitly.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_HYPER = 2'd2,
    PRIV_RSVD  = 2'd3
  } priv_e;

  // Privilege gate: one enable bit per level, reserved level never counts.
  function automatic logic mode_hit(input logic [2:0] mask, input priv_e p);
    case (p)
      PRIV_USER:  return mask[0];
      PRIV_SUPER: return mask[1];
      PRIV_HYPER: return mask[2];
      default:    return 1'b0;
    endcase
  endfunction

  // Threshold compare, widened so that callers of any width share it.
  function automatic logic meets_thresh(input logic [31:0] qty,
                                        input logic [31:0] thr,
                                        input logic        inv);
    return inv ? (qty < thr) : (qty >= thr);
  endfunction

  // Overflow is a 0->1 change of the top bit caused by an increment.
  function automatic logic top_bit_rise(input logic old_msb, input logic new_msb);
    return !old_msb && new_msb;
  endfunction

endpackage

// File: rtl/pfc_cfg_reg.sv
module pfc_cfg_reg #(
  parameter int SELW = 2,
  parameter int EVW  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [SELW-1:0] sel_d,
  input  logic [EVW-1:0]  umask_d,
  input  logic [2:0]      modes_d,
  input  logic [EVW-1:0]  thresh_d,
  input  logic            inv_d,
  input  logic            edge_d,
  input  logic            inten_d,
  input  logic            pinctl_d,
  output logic [SELW-1:0] sel_q,
  output logic [EVW-1:0]  umask_q,
  output logic [2:0]      modes_q,
  output logic [EVW-1:0]  thresh_q,
  output logic            inv_q,
  output logic            edge_q,
  output logic            inten_q,
  output logic            pinctl_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= '0;
      umask_q  <= '0;
      modes_q  <= '0;
      thresh_q <= '0;
      inv_q    <= 1'b0;
      edge_q   <= 1'b0;
      inten_q  <= 1'b0;
      pinctl_q <= 1'b0;
    end else if (we) begin
      sel_q    <= sel_d;
      umask_q  <= umask_d;
      modes_q  <= modes_d;
      thresh_q <= thresh_d;
      inv_q    <= inv_d;
      edge_q   <= edge_d;
      inten_q  <= inten_d;
      pinctl_q <= pinctl_d;
    end
  end

endmodule

// File: rtl/pfc_event_filter.sv
module pfc_event_filter
  import pfc_pkg::*;
#(
  parameter int                    NUM_EVENTS  = 4,
  parameter int                    EVW         = 8,
  parameter int                    SELW        = 2,
  parameter logic [NUM_EVENTS-1:0] EVT_IS_MASK = 4'b1010
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_EVENTS*EVW-1:0] evt_in,
  input  logic [1:0]                priv_mode,
  input  logic [SELW-1:0]           sel,
  input  logic [EVW-1:0]            umask,
  input  logic [2:0]                modes,
  input  logic [EVW-1:0]            thresh,
  input  logic                      inv,
  input  logic                      edge_en,
  input  logic                      clr_hist,
  output logic                      mode_ok,
  output logic                      thr_nz,
  output logic                      cond,
  output logic [EVW-1:0]            inc
);

  function automatic logic [EVW-1:0] ones(input logic [EVW-1:0] v);
    logic [EVW-1:0] n;
    n = '0;
    for (int b = 0; b < EVW; b++) n = n + EVW'(v[b]);
    return n;
  endfunction

  logic [EVW-1:0] qty_arr [NUM_EVENTS];
  logic [EVW-1:0] qty_sel;
  logic [EVW-1:0] level_inc;
  logic           cmp;
  logic           hist_q;

  // Per-source quantity: bitmask sources are masked and reduced to a count.
  for (genvar k = 0; k < NUM_EVENTS; k++) begin : g_src
    if (EVT_IS_MASK[k]) begin : g_mask
      assign qty_arr[k] = ones(evt_in[k*EVW +: EVW] & umask);
    end else begin : g_cnt
      assign qty_arr[k] = evt_in[k*EVW +: EVW];
    end
  end

  always_comb begin
    qty_sel = '0;
    for (int k = 0; k < NUM_EVENTS; k++) begin
      if (sel == SELW'(k)) qty_sel = qty_arr[k];
    end
  end

  assign mode_ok   = mode_hit(modes, priv_e'(priv_mode));
  assign thr_nz    = |thresh;
  assign cmp       = meets_thresh(32'(qty_sel), 32'(thresh), inv);
  assign cond      = mode_ok && (thr_nz ? cmp : |qty_sel);
  assign level_inc = thr_nz ? EVW'(cond) : (mode_ok ? qty_sel : '0);
  assign inc       = edge_en ? EVW'(cond && !hist_q) : level_inc;

  always_ff @(posedge clk) begin
    if (!rst_n)        hist_q <= 1'b0;
    else if (clr_hist) hist_q <= 1'b0;
    else               hist_q <= cond;
  end

endmodule

// File: rtl/pfc_accum.sv
module pfc_accum
  import pfc_pkg::*;
#(
  parameter int CW = 64,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] inc,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  input  logic          inten,
  input  logic          pinctl,
  output logic [CW-1:0] count,
  output logic          irq,
  output logic          pin,
  output logic          ovf_pulse
);

  logic [CW-1:0] sum;

  assign sum       = count + {{(CW-IW){1'b0}}, inc};
  assign ovf_pulse = !wr_en && top_bit_rise(count[CW-1], sum[CW-1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      irq   <= 1'b0;
      pin   <= 1'b0;
    end else begin
      count <= wr_en ? wr_data : sum;
      if (wr_en)                irq <= 1'b0;
      else if (ovf_pulse && inten) irq <= 1'b1;
      if (ovf_pulse && pinctl)  pin <= !pin;
    end
  end

endmodule

// File: rtl/pfc_counter.sv
module pfc_counter
  import pfc_pkg::*;
#(
  parameter int                    NUM_EVENTS  = 4,
  parameter int                    EVW         = 8,
  parameter int                    CW          = 64,
  parameter logic [NUM_EVENTS-1:0] EVT_IS_MASK = 4'b1010,
  localparam int                   SELW        = (NUM_EVENTS > 1) ? $clog2(NUM_EVENTS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                priv_mode,
  input  logic [NUM_EVENTS*EVW-1:0] evt_in,
  input  logic                      cfg_we,
  input  logic [SELW-1:0]           cfg_sel,
  input  logic [EVW-1:0]            cfg_umask,
  input  logic [2:0]                cfg_modes,
  input  logic [EVW-1:0]            cfg_thresh,
  input  logic                      cfg_inv,
  input  logic                      cfg_edge,
  input  logic                      cfg_inten,
  input  logic                      cfg_pinctl,
  input  logic                      cnt_we,
  input  logic [CW-1:0]             cnt_wdata,
  output logic [CW-1:0]             count,
  output logic                      irq,
  output logic                      pin_out
);

  logic [SELW-1:0] sel_q;
  logic [EVW-1:0]  umask_q;
  logic [2:0]      modes_q;
  logic [EVW-1:0]  thresh_q;
  logic            inv_q;
  logic            edge_q;
  logic            inten_q;
  logic            pinctl_q;

  // Named internal events, observed by the bound checker.
  logic            mode_ok;
  logic            thr_nz;
  logic            flt_cond;
  logic            ovf_pulse;
  logic [EVW-1:0]  flt_inc;

  pfc_cfg_reg #(.SELW(SELW), .EVW(EVW)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .sel_d    (cfg_sel),
    .umask_d  (cfg_umask),
    .modes_d  (cfg_modes),
    .thresh_d (cfg_thresh),
    .inv_d    (cfg_inv),
    .edge_d   (cfg_edge),
    .inten_d  (cfg_inten),
    .pinctl_d (cfg_pinctl),
    .sel_q    (sel_q),
    .umask_q  (umask_q),
    .modes_q  (modes_q),
    .thresh_q (thresh_q),
    .inv_q    (inv_q),
    .edge_q   (edge_q),
    .inten_q  (inten_q),
    .pinctl_q (pinctl_q)
  );

  pfc_event_filter #(
    .NUM_EVENTS  (NUM_EVENTS),
    .EVW         (EVW),
    .SELW        (SELW),
    .EVT_IS_MASK (EVT_IS_MASK)
  ) u_filt (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_in    (evt_in),
    .priv_mode (priv_mode),
    .sel       (sel_q),
    .umask     (umask_q),
    .modes     (modes_q),
    .thresh    (thresh_q),
    .inv       (inv_q),
    .edge_en   (edge_q),
    .clr_hist  (cnt_we),
    .mode_ok   (mode_ok),
    .thr_nz    (thr_nz),
    .cond      (flt_cond),
    .inc       (flt_inc)
  );

  pfc_accum #(.CW(CW), .IW(EVW)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc       (flt_inc),
    .wr_en     (cnt_we),
    .wr_data   (cnt_wdata),
    .inten     (inten_q),
    .pinctl    (pinctl_q),
    .count     (count),
    .irq       (irq),
    .pin       (pin_out),
    .ovf_pulse (ovf_pulse)
  );

endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
  parameter int CW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cnt_we,
  input logic [CW-1:0] cnt_wdata,
  input logic [CW-1:0] count,
  input logic          irq,
  input logic          pin_out,
  input logic          mode_ok,
  input logic          thr_nz,
  input logic          edge_q,
  input logic          inten_q,
  input logic          pinctl_q,
  input logic          ovf_pulse
);

  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> count == $past(cnt_wdata));

  a_r2_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_ok && !cnt_we) |=> $stable(count));

  a_r5_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_nz && !cnt_we) |=> (count - $past(count)) <= CW'(1));

  a_r7_edge_step: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_q && !cnt_we) |=> (count - $past(count)) <= CW'(1));

  a_r9_ovf_sets_msb: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> count[CW-1]);

  a_r10_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !cnt_we) |=> irq);

  a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !(ovf_pulse && inten_q)) |=> !irq);

  a_r11_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_pulse && pinctl_q) |=> $stable(pin_out));

  a_r11_pin_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_pulse && pinctl_q) |=> pin_out != $past(pin_out));

endmodule

bind pfc_counter pfc_checker #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_we    (cnt_we),
  .cnt_wdata (cnt_wdata),
  .count     (count),
  .irq       (irq),
  .pin_out   (pin_out),
  .mode_ok   (mode_ok),
  .thr_nz    (thr_nz),
  .edge_q    (edge_q),
  .inten_q   (inten_q),
  .pinctl_q  (pinctl_q),
  .ovf_pulse (ovf_pulse)
);

// File: tb/pfc_counter_test.sv
`timescale 1ns/1ps
module pfc_counter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  priv_mode = 2'd0;
  logic [31:0] evt_in = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [7:0]  cfg_umask = '0;
  logic [2:0]  cfg_modes = '0;
  logic [7:0]  cfg_thresh = '0;
  logic        cfg_inv = 1'b0, cfg_edge = 1'b0, cfg_inten = 1'b0, cfg_pinctl = 1'b0;
  logic        cnt_we = 1'b0;
  logic [63:0] cnt_wdata = '0;
  logic [63:0] count;
  logic        irq, pin_out;

  always #4 clk = ~clk;  // 125 MHz

  pfc_counter uut (
    .clk(clk), .rst_n(rst_n), .priv_mode(priv_mode), .evt_in(evt_in),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_umask(cfg_umask), .cfg_modes(cfg_modes),
    .cfg_thresh(cfg_thresh), .cfg_inv(cfg_inv), .cfg_edge(cfg_edge),
    .cfg_inten(cfg_inten), .cfg_pinctl(cfg_pinctl), .cnt_we(cnt_we),
    .cnt_wdata(cnt_wdata), .count(count), .irq(irq), .pin_out(pin_out)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Reference model state
  logic [63:0] m_count = '0;
  bit m_irq = 0, m_pin = 0, m_hist = 0;
  int m_sel = 0, m_umask = 0, m_modes = 0, m_thr = 0;
  bit m_inv = 0, m_edge = 0, m_inten = 0, m_pinctl = 0;

  function automatic int quantity(int sel, int umask, logic [31:0] ev);
    int field = (ev >> (8 * sel)) & 255;
    int n = 0;
    if (sel == 1 || sel == 3) begin  // bitmask sources (R4)
      field = field & umask;
      while (field != 0) begin
        n += field & 1;
        field = field >> 1;
      end
      return n;
    end
    return field;
  endfunction

  task automatic model_step();
    int q = quantity(m_sel, m_umask, evt_in);
    bit lvl = (priv_mode != 2'd3) && (((m_modes >> priv_mode) & 1) == 1);
    bit c;
    int add;
    logic [63:0] nxt;
    if (m_thr == 0) c = lvl && (q != 0);
    else if (m_inv) c = lvl && (q < m_thr);
    else c = lvl && (q >= m_thr);
    if (m_edge) add = (c && !m_hist) ? 1 : 0;
    else if (m_thr == 0) add = lvl ? q : 0;
    else add = c ? 1 : 0;
    if (cnt_we) begin
      m_count = cnt_wdata;
      m_irq = 0;
      m_hist = 0;
    end else begin
      nxt = m_count + 64'(add);
      if (!m_count[63] && nxt[63]) begin
        if (m_inten) m_irq = 1;
        if (m_pinctl) m_pin = !m_pin;
      end
      m_count = nxt;
      m_hist = c;
    end
    if (cfg_we) begin
      m_sel = cfg_sel; m_umask = cfg_umask; m_modes = cfg_modes; m_thr = cfg_thresh;
      m_inv = cfg_inv; m_edge = cfg_edge; m_inten = cfg_inten; m_pinctl = cfg_pinctl;
    end
  endtask

  task automatic compare(string tag);
    total++;
    if (count !== m_count) begin
      bad++;
      $display("FAIL %s count actual=%h expected=%h", tag, count, m_count);
    end
    total++;
    if (irq !== m_irq) begin
      bad++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, m_irq);
    end
    total++;
    if (pin_out !== m_pin) begin
      bad++;
      $display("FAIL %s pin actual=%b expected=%b", tag, pin_out, m_pin);
    end
  endtask

  task automatic tick(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    cfg_we = 0;
    cnt_we = 0;
  endtask

  task automatic cfg(int sel, int um, int md, int th, bit inv, bit edg, bit ie, bit pc);
    cfg_we = 1; cfg_sel = 2'(sel); cfg_umask = 8'(um); cfg_modes = 3'(md);
    cfg_thresh = 8'(th); cfg_inv = inv; cfg_edge = edg; cfg_inten = ie; cfg_pinctl = pc;
    evt_in = '0;
    tick("cfg");
  endtask

  task automatic ev(int pm, logic [31:0] v, string tag);
    priv_mode = 2'(pm);
    evt_in = v;
    tick(tag);
  endtask

  task automatic wr(logic [63:0] v, string tag);
    cnt_we = 1;
    cnt_wdata = v;
    evt_in = '0;
    tick(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1;
    ev(0, 32'hFFFF_FFFF, "R1 idle");
    ev(2, 32'h0505_0505, "R1 idle");

    // R3 raw count of a count-type source
    cfg(0, 0, 7, 0, 0, 0, 0, 0);
    ev(0, 32'h0000_0005, "R3 raw");
    ev(1, 32'h0000_00C8, "R3 raw");
    ev(0, 32'h0000_0900, "R3 other source not selected");

    // R2 privilege gating
    cfg(0, 0, 1, 0, 0, 0, 0, 0);
    ev(1, 32'h7, "R2 super blocked");
    ev(3, 32'h7, "R2 reserved blocked");
    ev(0, 32'h7, "R2 user counts");
    cfg(0, 0, 4, 0, 0, 0, 0, 0);
    ev(2, 32'h3, "R2 hyper counts");
    ev(0, 32'h3, "R2 user blocked");

    // R4 bitmask source and unit mask
    cfg(1, 8'h0F, 7, 0, 0, 0, 0, 0);
    ev(0, 32'h0000_FF00, "R4 masked popcount");
    ev(0, 32'h0000_F000, "R4 masked out");
    cfg(3, 8'h81, 7, 0, 0, 0, 0, 0);
    ev(0, 32'hFF00_0000, "R4 source 3");
    cfg(0, 8'h01, 7, 0, 0, 0, 0, 0);
    ev(0, 32'h0000_0009, "R4 mask ignored on count source");

    // R5 threshold
    cfg(0, 0, 7, 3, 0, 0, 0, 0);
    ev(0, 32'h2, "R5 below");
    ev(0, 32'h3, "R5 equal");
    ev(0, 32'hC8, "R5 above");

    // R6 invert
    cfg(0, 0, 7, 3, 1, 0, 0, 0);
    ev(0, 32'h2, "R6 below counts");
    ev(0, 32'h3, "R6 equal blocked");
    cfg(0, 0, 7, 0, 1, 0, 0, 0);
    ev(0, 32'h4, "R6 zero threshold ignores invert");

    // R7 edge detection
    cfg(0, 0, 7, 1, 0, 1, 0, 0);
    ev(0, 32'h1, "R7 rise");
    ev(0, 32'h5, "R7 held");
    ev(0, 32'h0, "R7 fall");
    ev(0, 32'h2, "R7 rise again");

    // R8 write priority and history clear
    ev(0, 32'h1, "R8 held");
    cnt_we = 1; cnt_wdata = 64'd100; priv_mode = 0; evt_in = 32'h1;
    tick("R8 write wins");
    ev(0, 32'h1, "R8 history cleared");

    // R9/R10/R11 overflow
    cfg(0, 0, 7, 0, 0, 0, 1, 1);
    wr(64'h7FFF_FFFF_FFFF_FFFE, "R9 preload");
    ev(0, 32'h5, "R9 R10 R11 crossing");
    ev(0, 32'h5, "R10 held");
    wr(64'hFFFF_FFFF_FFFF_FFFE, "R10 write clears");
    ev(0, 32'h5, "R9 wrap not overflow");
    wr(64'h8000_0000_0000_0000, "R9 write not overflow");
    ev(0, 32'h0, "R9 write not overflow");
    cfg(0, 0, 7, 0, 0, 0, 0, 1);
    wr(64'h7FFF_FFFF_FFFF_FFFF, "R11 preload");
    ev(0, 32'h1, "R11 pin without irq");
    cfg(0, 0, 7, 0, 0, 0, 1, 0);
    wr(64'h7FFF_FFFF_FFFF_FFF0, "R10 preload");
    ev(0, 32'hFF, "R11 no pin when disabled");

    // Mixed random traffic, all requirements
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 4) begin
        cfg_we = 1; cfg_sel = 2'($urandom); cfg_umask = 8'($urandom);
        cfg_modes = 3'($urandom); cfg_thresh = ($urandom_range(0, 1) == 1) ? 8'($urandom_range(0, 6)) : 8'd0;
        cfg_inv = 1'($urandom); cfg_edge = 1'($urandom);
        cfg_inten = 1'($urandom); cfg_pinctl = 1'($urandom);
      end else if (r < 7) begin
        cnt_we = 1;
        cnt_wdata = ($urandom_range(0, 1) == 1) ? 64'h7FFF_FFFF_FFFF_FE00 : 64'hFFFF_FFFF_FFFF_FF00;
      end
      priv_mode = 2'($urandom);
      evt_in = $urandom;
      tick("R2 R4 R5 R6 R7 R9 R10 R11 random");
    end

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule